// File: doc/BRIEF.md
# SD Host Command Register Unit

This unit is the software-facing command half of an SD card host. A processor reaches it through a simple register port: one write strobe, an address and write data, with read data returned combinationally for the address presented. It holds the command word, the argument, a configuration word, a status word, four response words, a one-bit power control and a debug word. Writing the command register with its start bit set sends a request on a card-side port. That request carries a 6-bit command index and the 32-bit argument, and it is held under a valid/ready handshake.

After the request is taken, the unit waits for one reply beat. The beat carries a 2-bit length code and a 128-bit response field. The unit judges the length against the response type that the command word asked for. A good response is unpacked into the response words. A bad one sets a failure flag in the command word and a command-timeout bit in status. A completed busy-wait command can raise a busy interrupt. The single interrupt output follows the three interrupt-class status bits, which software clears by writing ones. Line signalling, CRC, clock division, timeout counting and the data path are handled by other blocks.

Top module: `sdh_cmd_regs`

## Requirements
- R1: After reset the command, argument, status, configuration, power and response registers read 0, the debug register reads 0x0000C60F, and irq_o and cmd_valid_o are low.
- R2: The register map uses these byte offsets: command 0x00, argument 0x04, status 0x20, power 0x30, debug 0x34, configuration 0x38, and response word k at 0x10+4k. In the command word, bits 5:0 are the index, bit 9 asks for a long response, bit 10 means no response, bit 11 asks for busy wait, bit 14 is the failure flag and bit 15 is start. A command write with bit 15 set, made while the unit is idle, raises cmd_valid_o on the next cycle. cmd_idx_o then equals bits 5:0 and cmd_arg_o equals the argument register. Both stay steady until cmd_ready_i is seen high. Bit 15 reads 1 until the reply is taken and 0 afterwards. A command write without bit 15 just stores the word.
- R3: While a command is outstanding, writes to the command and argument registers are ignored.
- R4: Length codes are 0 none, 1 four bytes, 2 sixteen bytes and 3 error. The first reply byte is rsp_data_i[127:120]. A four-byte reply sets word 0 to rsp_data_i[127:96], big-endian, and clears words 1 to 3.
- R5: A sixteen-byte reply sets response word k to rsp_data_i[32k+31:32k]. Word 3 therefore holds the first four bytes and word 0 the last four.
- R6: The command fails on length code 3. When a response is expected, it also fails on code 0, or on code 1 when a long response was asked for. A failure sets command bit 14 and status bit 6 (0x40) and leaves the response words unchanged.
- R7: With the no-response bit set, length codes 0, 1 and 2 complete without failure and leave the response words unchanged.
- R8: A command that completes without failure, has bit 11 set and has configuration bit 10 set sets status bit 10 (0x400). The bit is not set otherwise.
- R9: A status write clears exactly the bits written as 1.
- R10: irq_o is high exactly while any of status bits 10, 9 or 8 is set.
- R11: A debug write whose low nibble is 0xF stores that nibble as 0. Any other value is stored as written.
- R12: Writes to offsets 0x08 and 0x0C change nothing. Reads of offsets outside the map return 0. The power register keeps only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |
| cmd_valid_o | output | 1 | Card-side request valid |
| cmd_ready_i | input | 1 | Card-side request accepted |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| rsp_valid_i | input | 1 | Reply beat valid |
| rsp_len_i | input | 2 | Reply length code |
| rsp_data_i | input | 32*RSP_WORDS | Reply bits, first byte at the top |

## Verification
The bench builds the unit with its defaults: an 8-bit offset, four response words and the 0x0000C60F debug reset value. With four words, all four response offsets and the full 128-bit reverse unpacking can be reached. That lets the bench see a short reply clear words left by an earlier long reply. It also exercises every combination of length code against the no-response and long-response flags, the busy interrupt with and without its enable and on a failed command, and writes made during a stretched request phase.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned CMD_W = 16;
  localparam int unsigned IDX_W = 6;
  localparam int unsigned ST_W  = 11;
  localparam int unsigned CFG_W = 11;

  localparam int unsigned OFS_CMD  = 'h00;
  localparam int unsigned OFS_ARG  = 'h04;
  localparam int unsigned OFS_TOUT = 'h08;
  localparam int unsigned OFS_CDIV = 'h0C;
  localparam int unsigned OFS_RSP  = 'h10;
  localparam int unsigned OFS_ST   = 'h20;
  localparam int unsigned OFS_PWR  = 'h30;
  localparam int unsigned OFS_DBG  = 'h34;
  localparam int unsigned OFS_CFG  = 'h38;

  localparam int unsigned CB_START = 15;
  localparam int unsigned CB_FAIL  = 14;
  localparam int unsigned CB_BUSYW = 11;
  localparam int unsigned CB_NORSP = 10;
  localparam int unsigned CB_LONG  = 9;

  localparam int unsigned SB_BUSY = 10;
  localparam int unsigned SB_BLK  = 9;
  localparam int unsigned SB_DATA = 8;
  localparam int unsigned SB_CTO  = 6;

  localparam int unsigned FB_BUSY_EN = 10;

  typedef enum logic [1:0] {
    RLEN_NONE = 2'd0,
    RLEN_4B   = 2'd1,
    RLEN_16B  = 2'd2,
    RLEN_ERR  = 2'd3
  } rsp_len_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sdh_cmd_seq.sv
module sdh_cmd_seq
  import sdh_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic cmd_ready_i,
  input  logic rsp_valid_i,
  output logic cmd_valid_o,
  output logic busy_o,
  output logic done_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE: if (launch_i)    st_d = SEQ_REQ;
      SEQ_REQ:  if (cmd_ready_i) st_d = SEQ_WAIT;
      SEQ_WAIT: if (rsp_valid_i) st_d = SEQ_IDLE;
      default:                   st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  assign cmd_valid_o = (st_q == SEQ_REQ);
  assign busy_o      = (st_q != SEQ_IDLE);
  // reply beats outside the wait state are dropped
  assign done_o      = (st_q == SEQ_WAIT) && rsp_valid_i;
endmodule

// File: rtl/sdh_rsp_eval.sv
module sdh_rsp_eval
  import sdh_pkg::*;
#(
  parameter int unsigned RSP_WORDS = 4,
  localparam int unsigned RSP_W    = RSP_WORDS * REG_W
) (
  input  rsp_len_e                      len_i,
  input  logic [RSP_W-1:0]              data_i,
  input  logic                          no_rsp_i,
  input  logic                          long_i,
  output logic                          fail_o,
  output logic                          store_o,
  output logic [RSP_WORDS-1:0][REG_W-1:0] words_o
);
  logic len_bad;

  always_comb begin
    len_bad = (len_i == RLEN_NONE) || ((len_i == RLEN_4B) && long_i);
    fail_o  = (len_i == RLEN_ERR) || (!no_rsp_i && len_bad);
    store_o = !fail_o && !no_rsp_i;
  end

  for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
    if (k == 0) begin : g_low
      assign words_o[k] = (len_i == RLEN_16B) ? data_i[REG_W-1:0]
                                              : data_i[RSP_W-1 -: REG_W];
    end else begin : g_high
      assign words_o[k] = (len_i == RLEN_16B) ? data_i[k*REG_W +: REG_W] : '0;
    end
  end
endmodule

// File: rtl/sdh_rd_mux.sv
module sdh_rd_mux
  import sdh_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned RSP_WORDS = 4
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [CMD_W-1:0]                cmd_i,
  input  logic [REG_W-1:0]                arg_i,
  input  logic [ST_W-1:0]                 st_i,
  input  logic [CFG_W-1:0]                cfg_i,
  input  logic                            pwr_i,
  input  logic [REG_W-1:0]                dbg_i,
  input  logic [RSP_WORDS-1:0][REG_W-1:0] rsp_i,
  output logic [REG_W-1:0]                rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CMD)) rdata_o = REG_W'(cmd_i);
    if (addr_i == ADDR_W'(OFS_ARG)) rdata_o = arg_i;
    if (addr_i == ADDR_W'(OFS_ST))  rdata_o = REG_W'(st_i);
    if (addr_i == ADDR_W'(OFS_CFG)) rdata_o = REG_W'(cfg_i);
    if (addr_i == ADDR_W'(OFS_PWR)) rdata_o = REG_W'(pwr_i);
    if (addr_i == ADDR_W'(OFS_DBG)) rdata_o = dbg_i;
    for (int k = 0; k < int'(RSP_WORDS); k++) begin
      if (addr_i == ADDR_W'(OFS_RSP + 4 * k)) rdata_o = rsp_i[k];
    end
  end
endmodule

// File: rtl/sdh_cmd_regs.sv
module sdh_cmd_regs
  import sdh_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned RSP_WORDS = 4,
  parameter logic [31:0] DBG_RST   = 32'h0000_C60F,
  localparam int unsigned RSP_W    = RSP_WORDS * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [5:0]        cmd_idx_o,
  output logic [31:0]       cmd_arg_o,
  input  logic              rsp_valid_i,
  input  logic [1:0]        rsp_len_i,
  input  logic [RSP_W-1:0]  rsp_data_i
);
  logic [CMD_W-1:0]                cmd_q;
  logic [REG_W-1:0]                arg_q;
  logic [ST_W-1:0]                 st_q, st_d;
  logic [CFG_W-1:0]                cfg_q;
  logic                            pwr_q;
  logic [REG_W-1:0]                dbg_q;
  logic [RSP_WORDS-1:0][REG_W-1:0] rsp_q, rsp_words;

  logic busy, done, fail, store, launch;
  logic wr_cmd, wr_arg, wr_st, wr_cfg, wr_pwr, wr_dbg;

  assign wr_cmd = reg_we_i && (reg_addr_i == ADDR_W'(OFS_CMD)) && !busy;
  assign wr_arg = reg_we_i && (reg_addr_i == ADDR_W'(OFS_ARG)) && !busy;
  assign wr_st  = reg_we_i && (reg_addr_i == ADDR_W'(OFS_ST));
  assign wr_cfg = reg_we_i && (reg_addr_i == ADDR_W'(OFS_CFG));
  assign wr_pwr = reg_we_i && (reg_addr_i == ADDR_W'(OFS_PWR));
  assign wr_dbg = reg_we_i && (reg_addr_i == ADDR_W'(OFS_DBG));
  assign launch = wr_cmd && reg_wdata_i[CB_START];

  sdh_cmd_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .cmd_ready_i (cmd_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .cmd_valid_o (cmd_valid_o),
    .busy_o      (busy),
    .done_o      (done)
  );

  sdh_rsp_eval #(.RSP_WORDS(RSP_WORDS)) u_eval (
    .len_i    (rsp_len_e'(rsp_len_i)),
    .data_i   (rsp_data_i),
    .no_rsp_i (cmd_q[CB_NORSP]),
    .long_i   (cmd_q[CB_LONG]),
    .fail_o   (fail),
    .store_o  (store),
    .words_o  (rsp_words)
  );

  // completion sets win over a same-cycle clear
  always_comb begin
    st_d = st_q;
    if (wr_st) st_d = st_q & ~reg_wdata_i[ST_W-1:0];
    if (done) begin
      if (fail) st_d[SB_CTO] = 1'b1;
      else if (cmd_q[CB_BUSYW] && cfg_q[FB_BUSY_EN]) st_d[SB_BUSY] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      arg_q <= '0;
      st_q  <= '0;
      cfg_q <= '0;
      pwr_q <= 1'b0;
      dbg_q <= DBG_RST;
      rsp_q <= '0;
    end else begin
      st_q <= st_d;
      if (wr_cmd) cmd_q <= reg_wdata_i[CMD_W-1:0];
      if (done) begin
        cmd_q[CB_START] <= 1'b0;
        if (fail) cmd_q[CB_FAIL] <= 1'b1;
        if (store) rsp_q <= rsp_words;
      end
      if (wr_arg) arg_q <= reg_wdata_i;
      if (wr_cfg) cfg_q <= reg_wdata_i[CFG_W-1:0];
      if (wr_pwr) pwr_q <= reg_wdata_i[0];
      if (wr_dbg) dbg_q <= (reg_wdata_i[3:0] == 4'hF) ? {reg_wdata_i[31:4], 4'h0}
                                                     : reg_wdata_i;
    end
  end

  sdh_rd_mux #(.ADDR_W(ADDR_W), .RSP_WORDS(RSP_WORDS)) u_rd (
    .addr_i  (reg_addr_i),
    .cmd_i   (cmd_q),
    .arg_i   (arg_q),
    .st_i    (st_q),
    .cfg_i   (cfg_q),
    .pwr_i   (pwr_q),
    .dbg_i   (dbg_q),
    .rsp_i   (rsp_q),
    .rdata_o (reg_rdata_o)
  );

  assign irq_o     = st_q[SB_BUSY] | st_q[SB_BLK] | st_q[SB_DATA];
  assign cmd_idx_o = cmd_q[IDX_W-1:0];
  assign cmd_arg_o = arg_q;
endmodule

// File: rtl/sdh_cmd_chk.sv
module sdh_cmd_chk
  import sdh_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [3:0]        wnib_i,
  input logic              cmd_valid_i,
  input logic              cmd_ready_i,
  input logic [5:0]        cmd_idx_i,
  input logic [31:0]       cmd_arg_i,
  input logic              rsp_valid_i,
  input logic [1:0]        rsp_len_i,
  input logic              irq_i,
  input logic              start_q_i,
  input logic              fail_q_i,
  input logic [5:0]        idx_q_i,
  input logic              cto_q_i,
  input logic [3:0]        dbg_nib_q_i
);
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !cmd_ready_i |=> cmd_valid_i && $stable(cmd_idx_i) && $stable(cmd_arg_i));

  p_req_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> start_q_i);

  p_ignore_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q_i && reg_we_i && (reg_addr_i == ADDR_W'(OFS_CMD)) |=> idx_q_i == $past(idx_q_i));

  p_fail_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && start_q_i && !cmd_valid_i && (rsp_len_i == 2'd3)
    |=> fail_q_i && cto_q_i && !start_q_i);

  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(rsp_valid_i));

  p_dbg_nib_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && (reg_addr_i == ADDR_W'(OFS_DBG)) && (wnib_i == 4'hF) |=> dbg_nib_q_i == 4'h0);
endmodule

bind sdh_cmd_regs sdh_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .wnib_i      (reg_wdata_i[3:0]),
  .cmd_valid_i (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_idx_i   (cmd_idx_o),
  .cmd_arg_i   (cmd_arg_o),
  .rsp_valid_i (rsp_valid_i),
  .rsp_len_i   (rsp_len_i),
  .irq_i       (irq_o),
  .start_q_i   (cmd_q[15]),
  .fail_q_i    (cmd_q[14]),
  .idx_q_i     (cmd_q[5:0]),
  .cto_q_i     (st_q[6]),
  .dbg_nib_q_i (dbg_q[3:0])
);

// File: tb/sdh_cmd_regs_tb.sv
module sdh_cmd_regs_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq, cvalid, cready = 1'b0, rvalid = 1'b0;
  logic [5:0]   cidx;
  logic [31:0]  carg;
  logic [1:0]   rlen = '0;
  logic [127:0] rdat = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdh_cmd_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .cmd_valid_o(cvalid), .cmd_ready_i(cready), .cmd_idx_o(cidx),
    .cmd_arg_o(carg), .rsp_valid_i(rvalid), .rsp_len_i(rlen), .rsp_data_i(rdat)
  );

  localparam logic [127:0] LONG_D  = {32'h0A0B0C0D, 32'h11223344, 32'h55667788, 32'h1F2E3D4C};
  localparam logic [127:0] SHORT_D = {32'hA1B2C3D4, 96'hFFFF_FFFF_EEEE_EEEE_DDDD_DDDD};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic chk_rsp(input string req, input logic [31:0] w0, w1, w2, w3);
    rd_chk(req, 8'h10, w0);
    rd_chk(req, 8'h14, w1);
    rd_chk(req, 8'h18, w2);
    rd_chk(req, 8'h1C, w3);
  endtask

  // drives one command through the card port
  task automatic run_cmd(input logic [15:0] cw, input logic [31:0] arg,
                         input logic [1:0] len, input logic [127:0] data,
                         input int hold, input bit poke);
    wr(8'h04, arg);
    wr(8'h00, {16'h0, cw});
    chk("R2 valid", {31'h0, cvalid}, 32'h1);
    chk("R2 idx", {26'h0, cidx}, {26'h0, cw[5:0]});
    chk("R2 arg", carg, arg);
    rd_chk("R2 start pending", 8'h00, {16'h0, cw});
    for (int i = 0; i < hold; i++) @(negedge clk);
    if (poke) begin
      wr(8'h00, 32'h0000_8033);
      wr(8'h04, 32'hDEAD_0000);
      chk("R3 idx held", {26'h0, cidx}, {26'h0, cw[5:0]});
      chk("R3 arg held", carg, arg);
    end
    chk("R2 valid held", {31'h0, cvalid}, 32'h1);
    @(negedge clk); cready = 1'b1;
    @(negedge clk); cready = 1'b0;
    chk("R2 valid drop", {31'h0, cvalid}, 32'h0);
    @(negedge clk); rvalid = 1'b1; rlen = len; rdat = data;
    @(negedge clk); rvalid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 valid", {31'h0, cvalid}, 32'h0);
    rd_chk("R1 cmd", 8'h00, 32'h0);
    rd_chk("R1 arg", 8'h04, 32'h0);
    rd_chk("R1 status", 8'h20, 32'h0);
    rd_chk("R1 cfg", 8'h38, 32'h0);
    rd_chk("R1 pwr", 8'h30, 32'h0);
    rd_chk("R1 dbg", 8'h34, 32'h0000_C60F);
    chk_rsp("R1 rsp", 32'h0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic t_long();
    run_cmd(16'h8202, 32'h0000_0001, 2'd2, LONG_D, 3, 1'b1);
    rd_chk("R3 cmd unchanged", 8'h00, 32'h0000_0202);
    rd_chk("R3 arg unchanged", 8'h04, 32'h0000_0001);
    rd_chk("R5 status", 8'h20, 32'h0);
    chk_rsp("R5 words", 32'h1F2E3D4C, 32'h55667788, 32'h11223344, 32'h0A0B0C0D);
  endtask

  task automatic t_short();
    run_cmd(16'h8011, 32'h1234_5678, 2'd1, SHORT_D, 0, 1'b0);
    rd_chk("R2 start cleared", 8'h00, 32'h0000_0011);
    rd_chk("R4 status", 8'h20, 32'h0);
    chk_rsp("R4 words", 32'hA1B2C3D4, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic t_fail();
    run_cmd(16'h8209, 32'h9, 2'd1, LONG_D, 0, 1'b0);
    rd_chk("R6 short for long cmd", 8'h00, 32'h0000_4209);
    rd_chk("R6 short for long st", 8'h20, 32'h0000_0040);
    chk_rsp("R6 rsp kept", 32'hA1B2C3D4, 32'h0, 32'h0, 32'h0);
    chk("R6 irq", {31'h0, irq}, 32'h0);
    wr(8'h20, 32'h0000_07BF);
    rd_chk("R9 other bits", 8'h20, 32'h0000_0040);
    wr(8'h20, 32'h0000_0040);
    rd_chk("R9 clear", 8'h20, 32'h0);
    run_cmd(16'h8005, 32'h5, 2'd0, LONG_D, 1, 1'b0);
    rd_chk("R6 none cmd", 8'h00, 32'h0000_4005);
    rd_chk("R6 none st", 8'h20, 32'h0000_0040);
    chk_rsp("R6 none rsp kept", 32'hA1B2C3D4, 32'h0, 32'h0, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);
    rd_chk("R2 plain write", 8'h00, 32'h0);
  endtask

  task automatic t_noresp();
    run_cmd(16'h8400, 32'h0, 2'd2, LONG_D, 0, 1'b0);
    rd_chk("R7 cmd", 8'h00, 32'h0000_0400);
    rd_chk("R7 st", 8'h20, 32'h0);
    chk_rsp("R7 rsp kept", 32'hA1B2C3D4, 32'h0, 32'h0, 32'h0);
    run_cmd(16'h8401, 32'h0, 2'd1, LONG_D, 0, 1'b0);
    rd_chk("R7 four byte cmd", 8'h00, 32'h0000_0401);
    chk_rsp("R7 four byte rsp kept", 32'hA1B2C3D4, 32'h0, 32'h0, 32'h0);
    run_cmd(16'h8400, 32'h0, 2'd3, LONG_D, 0, 1'b0);
    rd_chk("R6 err cmd", 8'h00, 32'h0000_4400);
    rd_chk("R6 err st", 8'h20, 32'h0000_0040);
    wr(8'h20, 32'h0000_0040);
  endtask

  task automatic t_busy();
    wr(8'h38, 32'h0000_0400);
    rd_chk("R8 cfg", 8'h38, 32'h0000_0400);
    run_cmd(16'h8C07, 32'h7, 2'd0, '0, 0, 1'b0);
    rd_chk("R8 busy set", 8'h20, 32'h0000_0400);
    chk("R10 irq high", {31'h0, irq}, 32'h1);
    wr(8'h20, 32'h0000_0400);
    chk("R10 irq low", {31'h0, irq}, 32'h0);
    rd_chk("R9 busy cleared", 8'h20, 32'h0);
    wr(8'h38, 32'h0);
    run_cmd(16'h8C07, 32'h7, 2'd0, '0, 0, 1'b0);
    rd_chk("R8 no enable", 8'h20, 32'h0);
    chk("R8 no enable irq", {31'h0, irq}, 32'h0);
    wr(8'h38, 32'h0000_0400);
    run_cmd(16'h8807, 32'h7, 2'd3, '0, 0, 1'b0);
    rd_chk("R8 fail no busy", 8'h20, 32'h0000_0040);
    chk("R8 fail irq", {31'h0, irq}, 32'h0);
    rd_chk("R6 busy fail cmd", 8'h00, 32'h0000_4807);
    wr(8'h20, 32'h0000_0040);
  endtask

  task automatic t_misc();
    wr(8'h34, 32'h1234_567F);
    rd_chk("R11 nibble F", 8'h34, 32'h1234_5670);
    wr(8'h34, 32'hABCD_0005);
    rd_chk("R11 other", 8'h34, 32'hABCD_0005);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R12 tout read", 8'h08, 32'h0);
    rd_chk("R12 cdiv read", 8'h0C, 32'h0);
    rd_chk("R12 undefined", 8'h24, 32'h0);
    rd_chk("R12 cmd kept", 8'h00, 32'h0000_4807);
    rd_chk("R12 st kept", 8'h20, 32'h0);
    rd_chk("R12 cfg kept", 8'h38, 32'h0000_0400);
    chk_rsp("R12 rsp kept", 32'hA1B2C3D4, 32'h0, 32'h0, 32'h0);
    wr(8'h30, 32'hFFFF_FFFF);
    rd_chk("R12 pwr bit", 8'h30, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_long();
    t_short();
    t_fail();
    t_noresp();
    t_busy();
    t_misc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule